// File: doc/BRIEF.md
# SPI Flash Command Engine

The engine is a register-programmed SPI master for serial flash parts. Software loads up to four command bytes into a transmit register, then writes a control word that names the transfer lengths and one of four chip selects and triggers a send. The engine clocks the transmit bytes out, then clocks in up to four reply bytes. The serial clock idles high, MOSI changes after a falling clock edge, and MISO is sampled on the rising edge. When the engine releases chip select, it raises a sticky done flag that software clears.

Two single-bit shortcuts save software from building common commands. The first reads the flash status byte: the engine sends the fixed opcode for that command and places the reply in the low byte of the status register. The second issues write enable: the engine sends the fixed opcode for that command and receives nothing. The serial clock is the system clock divided by the parameter `HALF_DIV`. Every half period of the serial clock lasts `HALF_DIV` system cycles.

Top module: `sfc_engine`

## Requirements
- R1: When no chip select is asserted, sclk is high. During a transfer, MOSI changes only in the cycle in which sclk falls, MISO is sampled when sclk rises, and each byte travels most significant bit first.
- R2: Registers sit at these byte offsets: 0x00 mode, 0x04 command, 0x08 status, 0x0C transmit, 0x10 receive. Any other offset reads zero. In the mode register only bit 28 (software mode) and bit 29 (burst mode) are stored, and all its other bits read zero. After reset every register reads zero.
- R3: Writing the command register with bit 7 set starts a send. The engine shifts out the number of transmit bytes given in bits [2:0], taking the transmit register's bits [7:0] first, and then clocks in the number of bytes given in bits [6:4]. A count above 4 acts as 4, and a count of 0 means no bytes.
- R4: At the end of a send, received byte i sits in receive register bits [8i+7:8i]. Bytes that were not received read zero.
- R5: Command bit 10 sends opcode 0x05, receives one byte and places it in status bits [7:0]. The receive register keeps its value.
- R6: Command bit 11 sends opcode 0x06 alone, with no reply bytes. Status bits [7:0] and the receive register keep their values.
- R7: If several trigger bits are set in one write, only one job runs. Bit 11 wins over bit 10, and bit 10 wins over bit 7.
- R8: Command bits [13:12] give the index n of the chip select to use. During the transfer only cs_n[n] is low. All four chip selects are high when the engine is idle.
- R9: Chip select falls on the edge that accepts the trigger. The first falling edge of sclk comes HALF_DIV cycles later. Each half period of sclk lasts HALF_DIV cycles. Chip select rises HALF_DIV cycles after the last rising edge, so a transfer of N bits holds chip select low for HALF_DIV*(2N+1) cycles.
- R10: Status bit 8 is set on the edge on which chip select rises. A write of 0 to that bit clears it, and a write of 1 leaves it unchanged.
- R11: If a transfer completes on the same edge as a status write that clears bit 8, bit 8 ends up set.
- R12: While a transfer runs, writes to the command register are ignored entirely. Trigger bits always read back as zero, and the other command fields read back as last accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | 4 | Active-low chip selects |

## Verification
Completing a transfer and the software write that clears the done flag can land on the same clock edge. The bench takes the length of a one-byte send from the timing rule, counts cycles forward from the edge that accepted the trigger, and places a clear write of the status register on the exact edge on which chip select rises. A set-wins rule is judged correct when the flag then reads as set. An ordinary clear write, made outside that edge, is checked separately and must drop the flag.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int unsigned CS_COUNT = 4;
  localparam int unsigned ADDR_W   = 5;

  // register byte offsets
  localparam logic [ADDR_W-1:0] A_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] A_CMD  = 5'h04;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h08;
  localparam logic [ADDR_W-1:0] A_TXD  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_RXD  = 5'h10;

  // bit positions
  localparam int unsigned M_SW     = 28;
  localparam int unsigned M_BURST  = 29;
  localparam int unsigned C_SEND   = 7;
  localparam int unsigned C_RDSTAT = 10;
  localparam int unsigned C_WREN   = 11;
  localparam int unsigned S_DONE   = 8;

  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_WREN   = 8'h06;

  typedef enum logic [1:0] {JOB_SEND, JOB_RDSTAT, JOB_WREN} job_kind_e;

  typedef struct packed {
    job_kind_e   kind;
    logic [2:0]  txn;
    logic [2:0]  rxn;
    logic [1:0]  bank;
    logic [31:0] word;
  } job_t;

  // byte count field: values above four act as four
  function automatic logic [2:0] clamp_len(input logic [2:0] f);
    return (f > 3'd4) ? 3'd4 : f;
  endfunction

  // serial bit k -> word position (byte k/8, MSB of the byte first)
  function automatic logic [4:0] lane_pos(input logic [4:0] k);
    return {k[4:3], ~k[2:0]};
  endfunction

  // half-period index on which chip select is released: 2*bits + 1
  function automatic logic [7:0] last_phase(input logic [2:0] txn, input logic [2:0] rxn);
    logic [7:0] n;
    n = {5'b0, txn} + {5'b0, rxn};
    return (n << 4) + 8'd1;
  endfunction

endpackage

// File: rtl/sfc_half_tick.sv
module sfc_half_tick #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_every
      assign tick = run;
    end else begin : g_count
      localparam int unsigned   CW   = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (!run || cnt_q == LAST)  cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
      end

      assign tick = run && (cnt_q == LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R9
    end
  endgenerate

endmodule

// File: rtl/sfc_shift_seq.sv
module sfc_shift_seq
  import sfc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  job_t                job,
  input  logic                tick,
  input  logic                miso,
  output logic                busy,
  output logic                fin_evt,
  output logic [31:0]         rx_word,
  output logic                sclk,
  output logic                mosi,
  output logic [CS_COUNT-1:0] cs_n
);

  logic                busy_q, sclk_q, mosi_q;
  logic [CS_COUNT-1:0] cs_q;
  logic [7:0]          ph_q, last_q, ph_n, ph_m1;
  logic [5:0]          txbits_q;
  logic [31:0]         word_q, rx_q;
  logic [6:0]          k_fall, k_rise, r_idx;
  logic                accept;

  assign accept = start && !busy_q;
  assign ph_n   = ph_q + 8'd1;
  assign ph_m1  = ph_n - 8'd1;
  assign k_fall = ph_m1[7:1];
  assign k_rise = ph_n[7:1] - 7'd1;
  assign r_idx  = k_rise - {1'b0, txbits_q};

  // completion event: release of chip select on this edge
  assign fin_evt = busy_q && tick && (ph_n == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b1;
      mosi_q   <= 1'b0;
      cs_q     <= '1;
      ph_q     <= '0;
      last_q   <= '0;
      txbits_q <= '0;
      word_q   <= '0;
      rx_q     <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      sclk_q   <= 1'b1;
      mosi_q   <= 1'b0;
      cs_q     <= ~(CS_COUNT'(1) << job.bank);
      ph_q     <= '0;
      last_q   <= last_phase(job.txn, job.rxn);
      txbits_q <= {job.txn, 3'b000};
      word_q   <= job.word;
      rx_q     <= '0;
    end else if (busy_q && tick) begin
      ph_q <= ph_n;
      if (fin_evt) begin
        busy_q <= 1'b0;
        cs_q   <= '1;
        sclk_q <= 1'b1;
        mosi_q <= 1'b0;
      end else if (ph_n[0]) begin
        sclk_q <= 1'b0;
        mosi_q <= (k_fall < {1'b0, txbits_q}) ? word_q[lane_pos(k_fall[4:0])] : 1'b0;
      end else begin
        sclk_q <= 1'b1;
        if (k_rise >= {1'b0, txbits_q}) rx_q[lane_pos(r_idx[4:0])] <= miso;
      end
    end
  end

  assign busy    = busy_q;
  assign rx_word = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign cs_n    = cs_q;

  logic cs_act;
  assign cs_act = !(&cs_q);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_q)); // R8
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> sclk_q); // R1
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act) && !$stable(mosi_q)) |-> (!sclk_q && $past(sclk_q))); // R1
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R12

endmodule

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic              fin_evt,
  input  logic [31:0]       rx_word,
  output logic              start,
  output job_t              job
);

  logic        sw_q, burst_q, tff_q;
  logic [2:0]  txf_q, rxf_q;
  logic [1:0]  bank_q;
  logic [31:0] tx_q, rxd_q;
  logic [7:0]  fstat_q;
  job_kind_e   kind_q;

  logic wr_mode, wr_cmd, wr_stat, wr_txd, trig, clr_req;

  assign wr_mode = bus_wr && (bus_addr == A_MODE);
  assign wr_cmd  = bus_wr && (bus_addr == A_CMD) && !busy;
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_txd  = bus_wr && (bus_addr == A_TXD);
  assign trig    = bus_wdata[C_SEND] | bus_wdata[C_RDSTAT] | bus_wdata[C_WREN];
  assign start   = wr_cmd && trig;
  assign clr_req = wr_stat && !bus_wdata[S_DONE];

  // job decode, priority: write enable, status read, send
  always_comb begin
    job.bank = bus_wdata[13:12];
    if (bus_wdata[C_WREN]) begin
      job.kind = JOB_WREN;
      job.txn  = 3'd1;
      job.rxn  = 3'd0;
      job.word = {24'b0, OP_WREN};
    end else if (bus_wdata[C_RDSTAT]) begin
      job.kind = JOB_RDSTAT;
      job.txn  = 3'd1;
      job.rxn  = 3'd1;
      job.word = {24'b0, OP_RDSTAT};
    end else begin
      job.kind = JOB_SEND;
      job.txn  = clamp_len(bus_wdata[2:0]);
      job.rxn  = clamp_len(bus_wdata[6:4]);
      job.word = tx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q    <= 1'b0;
      burst_q <= 1'b0;
      txf_q   <= '0;
      rxf_q   <= '0;
      bank_q  <= '0;
      tx_q    <= '0;
      rxd_q   <= '0;
      fstat_q <= '0;
      tff_q   <= 1'b0;
      kind_q  <= JOB_SEND;
    end else begin
      if (wr_mode) begin
        sw_q    <= bus_wdata[M_SW];
        burst_q <= bus_wdata[M_BURST];
      end
      if (wr_cmd) begin
        txf_q  <= bus_wdata[2:0];
        rxf_q  <= bus_wdata[6:4];
        bank_q <= bus_wdata[13:12];
      end
      if (start) kind_q <= job.kind;
      if (wr_txd) tx_q <= bus_wdata;
      if (fin_evt) begin
        if (kind_q == JOB_SEND)   rxd_q   <= rx_word;
        if (kind_q == JOB_RDSTAT) fstat_q <= rx_word[7:0];
      end
      // completion wins over a same-cycle clear
      if (fin_evt)      tff_q <= 1'b1;
      else if (clr_req) tff_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_MODE: begin
        bus_rdata[M_SW]    = sw_q;
        bus_rdata[M_BURST] = burst_q;
      end
      A_CMD: begin
        bus_rdata[2:0]   = txf_q;
        bus_rdata[6:4]   = rxf_q;
        bus_rdata[13:12] = bank_q;
      end
      A_STAT: begin
        bus_rdata[7:0]    = fstat_q;
        bus_rdata[S_DONE] = tff_q;
      end
      A_TXD:   bus_rdata = tx_q;
      A_RXD:   bus_rdata = rxd_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tff_q && !clr_req) |=> tff_q); // R10
  AST_FIN_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> tff_q); // R11
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(bank_q) && $stable(txf_q) && $stable(rxf_q))); // R12

endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
  import sfc_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic [CS_COUNT-1:0] cs_n
);

  logic        start, busy, fin_evt, tick;
  job_t        job;
  logic [31:0] rx_word;

  sfc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .fin_evt   (fin_evt),
    .rx_word   (rx_word),
    .start     (start),
    .job       (job)
  );

  sfc_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  sfc_shift_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .job     (job),
    .tick    (tick),
    .miso    (miso),
    .busy    (busy),
    .fin_evt (fin_evt),
    .rx_word (rx_word),
    .sclk    (sclk),
    .mosi    (mosi),
    .cs_n    (cs_n)
  );

endmodule

// File: tb/sfc_engine_tb.sv
module sfc_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HD         = 2;

  localparam logic [4:0] O_MODE = 5'h00, O_CMD = 5'h04, O_STAT = 5'h08,
                         O_TXD = 5'h0C, O_RXD = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_n;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfc_engine #(.HALF_DIV(HD)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  // flash-side model and observers
  logic [63:0] mosi_log, miso_bits;
  int rise_cnt, fall_cnt, cs_low_cyc, lead_cyc;
  logic [3:0] cs_seen;

  always @(posedge sclk) if (cs_n !== 4'hF) begin
    mosi_log = {mosi_log[62:0], mosi};
    rise_cnt++;
  end
  always @(negedge sclk) if (cs_n !== 4'hF) begin
    if (fall_cnt < 64) miso = miso_bits[63 - fall_cnt];
    fall_cnt++;
  end
  always @(negedge clk) if (rst_n && cs_n !== 4'hF) begin
    cs_low_cyc++;
    cs_seen = cs_n;
    if (fall_cnt == 0) lead_cyc++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic arm(input logic [63:0] mb);
    wr(O_STAT, 32'h0);
    miso_bits = mb; mosi_log = '0;
    rise_cnt = 0; fall_cnt = 0; cs_low_cyc = 0; lead_cyc = 0; cs_seen = 4'hF;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(O_STAT, s);
      if (s[8]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(O_MODE, d); chk("R2 reset mode", d, 0);
    rd(O_CMD, d);  chk("R2 reset cmd", d, 0);
    rd(O_STAT, d); chk("R2 reset stat", d, 0);
    rd(O_TXD, d);  chk("R2 reset txd", d, 0);
    rd(O_RXD, d);  chk("R2 reset rxd", d, 0);
    chk("R8 reset cs", cs_n, 4'hF);
    chk("R1 reset sclk", sclk, 1);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(O_MODE, 32'hFFFF_FFFF); rd(O_MODE, d); chk("R2 mode bits", d, 32'h3000_0000);
    wr(O_MODE, 32'h0);         rd(O_MODE, d); chk("R2 mode clear", d, 0);
    rd(5'h14, d);              chk("R2 unmapped", d, 0);
    wr(O_CMD, 32'h0000_2035);  rd(O_CMD, d);  chk("R12 cmd fields", d, 32'h2035);
    chk("R12 no trigger no cs", cs_n, 4'hF);
  endtask

  task automatic t_read_id();
    logic [31:0] d;
    wr(O_TXD, 32'h9F);
    arm({8'h00, 8'hC2, 8'h20, 8'h17, 32'h0});
    wr(O_CMD, 32'h0000_20B1);
    wait_done();
    rd(O_RXD, d);
    chk("R4 id packed", d, 32'h0017_20C2);
    chk("R3 id bits", rise_cnt, 32);
    chk("R1 id opcode", mosi_log[31:24], 8'h9F);
    chk("R3 mosi idle in rx", mosi_log[23:0], 0);
    chk("R8 id cs", cs_seen, 4'b1011);
    chk("R9 id cs low", cs_low_cyc, HD*65);
    chk("R9 id lead", lead_cyc, HD);
    chk("R8 id released", cs_n, 4'hF);
  endtask

  task automatic t_erase();
    logic [31:0] d;
    wr(O_TXD, 32'h5634_12D8);
    arm(64'hFFFF_FFFF_FFFF_FFFF);
    wr(O_CMD, 32'h0000_0084);
    wait_done();
    chk("R3 erase frame", mosi_log[31:0], 32'hD812_3456);
    chk("R3 erase bits", rise_cnt, 32);
    rd(O_RXD, d);
    chk("R4 rx cleared", d, 0);
    chk("R8 erase cs", cs_seen, 4'b1110);
    chk("R9 erase cs low", cs_low_cyc, HD*65);
  endtask

  task automatic t_clamp();
    logic [31:0] d;
    wr(O_TXD, 32'hA1B2_C3D4);
    arm(0);
    wr(O_CMD, 32'h0000_1087);
    wait_done();
    chk("R3 clamp bits", rise_cnt, 32);
    chk("R3 clamp frame", mosi_log[31:0], 32'hD4C3_B2A1);
    arm({8'h3C, 8'h81, 48'h0});
    wr(O_CMD, 32'h0000_00A0);
    wait_done();
    chk("R3 rx only bits", rise_cnt, 16);
    rd(O_RXD, d);
    chk("R4 rx two bytes", d, 32'h0000_813C);
  endtask

  task automatic t_rdstat();
    logic [31:0] d;
    arm({8'h00, 8'hA5, 48'h0});
    wr(O_CMD, 32'h0000_3400);
    wait_done();
    rd(O_STAT, d);
    chk("R5 status byte", d, 32'h0000_01A5);
    chk("R5 opcode", mosi_log[15:8], 8'h05);
    chk("R5 bits", rise_cnt, 16);
    chk("R8 rdstat cs", cs_seen, 4'b0111);
    rd(O_RXD, d);
    chk("R5 rxd kept", d, 32'h0000_813C);
  endtask

  task automatic t_wren();
    logic [31:0] d;
    arm(64'hFFFF_FFFF_FFFF_FFFF);
    wr(O_CMD, 32'h0000_0800);
    wait_done();
    chk("R6 bits", rise_cnt, 8);
    chk("R6 opcode", mosi_log[7:0], 8'h06);
    rd(O_STAT, d); chk("R6 status kept", d[7:0], 8'hA5);
    rd(O_RXD, d);  chk("R6 rxd kept", d, 32'h0000_813C);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    arm(0);
    wr(O_CMD, 32'h0000_0C81);
    wait_done();
    chk("R7 wren wins bits", rise_cnt, 8);
    chk("R7 wren wins op", mosi_log[7:0], 8'h06);
    arm({8'h00, 8'h3C, 48'h0});
    wr(O_CMD, 32'h0000_0481);
    wait_done();
    chk("R7 rdstat wins bits", rise_cnt, 16);
    chk("R7 rdstat wins op", mosi_log[15:8], 8'h05);
    rd(O_STAT, d); chk("R7 rdstat result", d[7:0], 8'h3C);
  endtask

  task automatic t_done_flag();
    logic [31:0] d;
    rd(O_STAT, d); chk("R10 set after transfer", d[8], 1);
    wr(O_STAT, 32'h0000_0100);
    rd(O_STAT, d); chk("R10 write one keeps", d[8], 1);
    wr(O_STAT, 32'hFFFF_FEFF);
    rd(O_STAT, d); chk("R10 write zero clears", d, 32'h0000_003C);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    arm(0);
    wr(O_CMD, 32'h0000_0081);       // accepted edge E0; now at E0 + half
    repeat (HD*17 - 1) @(negedge clk);
    bus_wr = 1'b1; bus_addr = O_STAT; bus_wdata = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R11 released", cs_n, 4'hF);
    chk("R11 bits", rise_cnt, 8);
    rd(O_STAT, d);
    chk("R11 set wins", d[8], 1);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    wr(O_TXD, 32'h1122_3344);
    arm(0);
    wr(O_CMD, 32'h0000_1084);
    repeat (10) @(negedge clk);
    wr(O_CMD, 32'h0000_3081);
    wait_done();
    chk("R12 single job bits", rise_cnt, 32);
    chk("R12 cs kept", cs_seen, 4'b1101);
    rd(O_CMD, d);
    chk("R12 cmd unchanged", d, 32'h0000_1004);
    repeat (50) @(negedge clk);
    chk("R12 no second job", cs_low_cyc, HD*65);
    chk("R12 idle cs", cs_n, 4'hF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_read_id();
    t_erase();
    t_clamp();
    t_rdstat();
    t_wren();
    t_priority();
    t_done_flag();
    t_collide();
    t_busy();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule